// File: doc/BRIEF.md
# Double-Buffered SPI Master Transmitter

This block is a serial peripheral interface master that sends bytes out on a data line while it clocks a slave. A one-byte holding register sits in front of the shift register. The host can therefore queue the next byte while the current one is still shifting out. The block works only in mode 0: the clock is low when idle, the data line is sampled on the rising edge and it changes on the falling edge. Bits go out most-significant first. The serial clock half-period comes from a programmable count of system clock cycles. Every output changes on the system clock.

Two flags report separate conditions:

- `tx_empty` rises as soon as a queued byte moves into the shift register, even though that byte has only begun its first bit. It may also drive an interrupt through an enable input.
- `busy` stays high until the final bit of the last byte has completed.

The host drives the slave select line itself. It waits for `busy` to fall before it deasserts the select. If the host keeps the holding register filled, bytes follow each other with no idle clock gap. Each byte clocked in from the slave lands in a receive register and raises a receive-full flag.

Top module: `spi_dbuf_master`

## Requirements
- R1: `tx_empty` reads 1 whenever the holding register can take a byte. It reads 0 on the cycle after an accepted write. When the shifter is idle, the queued byte moves into the shifter one cycle later and `tx_empty` returns to 1.
- R2: `irq` equals `tx_empty` AND `irq_en`. `tx_empty` itself does not depend on `irq_en`.
- R3: On the cycle a byte enters the shifter, `busy` goes to 1 and `tx_empty` is already 1. `sclk` is still 0 and `mosi` already shows bit 7 of the byte.
- R4: `busy` stays 1 until the 8th falling `sclk` edge of the last byte. A single byte keeps `busy` high for exactly 16*H system cycles, where H is the half-period.
- R5: Mode 0 timing. `sclk` is 0 whenever `busy` is 0. `mosi` changes only when a byte loads or on a falling `sclk` edge. `miso` is sampled on each rising `sclk` edge.
- R6: The 8 bits on `mosi` at the rising edges are the written byte, bit 7 first.
- R7: A write while the holding register is full replaces the held byte. The earlier byte is never sent.
- R8: If a byte is waiting when the current byte ends, it loads on that same cycle. Every rising-edge-to-rising-edge interval inside the burst, including across byte boundaries, is 2*H cycles.
- R9: When no byte is waiting, `sclk` stays at 0 and `busy` at 0 between bytes. A later byte is still sent correctly.
- R10: H equals `clk_half`, and a value of 0 is treated as 1.
- R11: At the 8th falling edge of each byte, `rx_data` takes the 8 `miso` bits, MSB first, and `rx_full` goes to 1. A pulse on `rx_ack` clears `rx_full`.
- R12: One cycle after `en` is seen low, `busy` = 0, `sclk` = 0 and `tx_empty` = 1. Writes made while `en` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Block enable; low clears the transmit path |
| clk_half | input | DIV_W | SCLK half-period in system cycles (0 acts as 1) |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| irq_en | input | 1 | Interrupt enable for buffer-empty |
| rx_ack | input | 1 | Clears the receive-full flag |
| miso | input | 1 | Serial data from the slave |
| tx_empty | output | 1 | Holding register can accept a byte |
| irq | output | 1 | Buffer-empty interrupt |
| busy | output | 1 | A byte is still shifting |
| rx_data | output | DATA_W | Last received byte |
| rx_full | output | 1 | A new byte is in `rx_data` |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the slave |

## Verification
Timing of each result, counted from the clock edge that accepts a write:

| Result | When it is due |
|--------|----------------|
| `tx_empty` falls | Right after the accepting edge |
| Load into the shifter (`busy` rises, `tx_empty` rises) | One edge later, if the shifter is idle |
| First `sclk` rise | H edges after the load |
| `busy` and `rx_full` | 16*H edges after the load |

The bench drives inputs just after a rising edge. The monitor samples on falling edges, so each result is read one half-cycle after the edge that produced it. A scoreboard queue holds the expected transmit bytes in write order. A second queue holds the expected receive bytes, pushed when the 8th rising edge is seen. Both are compared as the design finishes frames. The monitor also times every rising-to-rising `sclk` interval while `busy` stays high, against the 2*H the bench computes.

// File: rtl/spi_dbuf_pkg.sv
// Shared types and helpers for the double-buffered SPI master.
// Assumes nothing beyond IEEE 1800-2017.
package spi_dbuf_pkg;

    // Shift engine state: idle (SCLK parked low) or running a byte.
    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_RUN  = 1'b1
    } sh_state_e;

endpackage

// File: rtl/spi_clk_div.sv
// Half-period tick generator for SCLK.
// Emits one-cycle 'tick' every 'half' system cycles while 'run' is high.
// Assumes 'half' >= 1 (clamped by the parent). Counter restarts from zero
// whenever 'run' is low or 'clr' is high.
module spi_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    // Tick when the counter has reached the programmed half-period.
    assign tick = run && (cnt_q >= half - DIV_W'(1));

    // Count system cycles within one SCLK half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/spi_hold_reg.sv
// One-entry holding register in front of the shifter.
// A write always lands (replacing any waiting byte); a take empties it.
// When a write and a take coincide, the write wins so the new byte waits.
// Assumes 'take' is only raised while 'full' is high.
module spi_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);

    // Track occupancy of the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            full <= 1'b0;
        end else if (wr) begin
            full <= 1'b1;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // Capture the host byte on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (en && wr) begin
            data <= wdata;
        end
    end

endmodule

// File: rtl/spi_shift_eng.sv
// Mode-0 shift engine: drives SCLK/MOSI, samples MISO, MSB first.
// On a half-period tick, a low SCLK rises (sample MISO) and a high SCLK
// falls (advance MOSI or finish the byte). After the last falling edge it
// reloads at once from the holding register when a byte waits there.
// Assumes 'tick' comes from a divider that runs only while 'active'.
module spi_shift_eng
    import spi_dbuf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BIT_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              miso,
    output logic              take,
    output logic              active,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_data
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    sh_state_e         state_q;
    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic [BIT_W-1:0]  bit_q;
    logic              sclk_q;
    logic              last_fall;

    // Final falling edge of the current byte.
    assign last_fall = (state_q == SH_RUN) && tick && sclk_q && (bit_q == LAST_BIT);
    // Pull a waiting byte when idle or right at the end of a byte.
    assign take      = en && hold_full && ((state_q == SH_IDLE) || last_fall);
    assign done      = en && last_fall;
    assign active    = (state_q == SH_RUN);
    assign sclk      = sclk_q;
    assign mosi      = tx_sh_q[DATA_W-1];

    // Main shift sequencer: load, rising edge, falling edge, finish.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state_q <= SH_IDLE;
            tx_sh_q <= '0;
            bit_q   <= '0;
            sclk_q  <= 1'b0;
        end else if (take) begin
            state_q <= SH_RUN;
            tx_sh_q <= hold_data;
            bit_q   <= '0;
            sclk_q  <= 1'b0;
        end else if (state_q == SH_RUN && tick) begin
            if (!sclk_q) begin
                sclk_q <= 1'b1;
            end else begin
                sclk_q <= 1'b0;
                if (bit_q == LAST_BIT) begin
                    state_q <= SH_IDLE;
                    tx_sh_q <= '0;
                end else begin
                    tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
                    bit_q   <= bit_q + BIT_W'(1);
                end
            end
        end
    end

    // Sample MISO on each rising SCLK edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh_q <= '0;
        end else if (en && state_q == SH_RUN && tick && !sclk_q) begin
            rx_sh_q <= {rx_sh_q[DATA_W-2:0], miso};
        end
    end

    // Publish the received byte at the end of each byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
        end else if (done) begin
            rx_data <= rx_sh_q;
        end
    end

endmodule

// File: rtl/spi_dbuf_master.sv
// Top level: double-buffered SPI master, mode 0, MSB first.
// Joins holding register, shift engine and SCLK divider, and keeps the
// receive-full flag and the buffer-empty interrupt. Slave select is left
// to the host, which should wait for 'busy' low before deasserting it.
module spi_dbuf_master #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [DIV_W-1:0]  clk_half,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_en,
    input  logic              rx_ack,
    input  logic              miso,
    output logic              tx_empty,
    output logic              irq,
    output logic              busy,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              sclk,
    output logic              mosi
);

    localparam int BIT_W = $clog2(DATA_W);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              tick;
    logic              active;
    logic              done;
    logic [DIV_W-1:0]  half_eff;

    // Half-period of zero is treated as one.
    assign half_eff = (clk_half == '0) ? DIV_W'(1) : clk_half;
    assign tx_empty = !hold_full;
    assign irq      = tx_empty && irq_en;
    assign busy     = active;

    spi_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .wr    (wr_stb),
        .wdata (wr_data),
        .take  (take),
        .full  (hold_full),
        .data  (hold_data)
    );

    spi_shift_eng #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .tick      (tick),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .miso      (miso),
        .take      (take),
        .active    (active),
        .sclk      (sclk),
        .mosi      (mosi),
        .done      (done),
        .rx_data   (rx_data)
    );

    spi_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!en),
        .run   (active),
        .half  (half_eff),
        .tick  (tick)
    );

    // Receive-full flag: set at byte end (wins over ack), cleared by ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_full <= 1'b0;
        end else if (done) begin
            rx_full <= 1'b1;
        end else if (rx_ack) begin
            rx_full <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_dbuf_master_chk.sv
// Property checker for spi_dbuf_master, attached by bind below.
// Observes ports only; assumes synchronous active-low reset.
module spi_dbuf_master_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic wr_stb,
    input logic irq_en,
    input logic tx_empty,
    input logic irq,
    input logic busy,
    input logic rx_full,
    input logic sclk,
    input logic mosi
);

    // R1: an accepted write fills the holding register.
    a_r1_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        en && wr_stb |=> !tx_empty);

    // R2: the interrupt stays off when its enable is low.
    a_r2_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R2: the interrupt follows the empty flag when enabled.
    a_r2_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en && tx_empty |-> irq);

    // R3: a byte entering the shifter frees the buffer before the first edge.
    a_r3_empty_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) && !$past(wr_stb) |-> tx_empty && !sclk);

    // R5: the clock is parked low whenever nothing shifts.
    a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    // R5: data holds still while the clock is high.
    a_r5_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        sclk && $past(sclk) |-> $stable(mosi));

    // R11: the receive flag rises only as the clock falls back low.
    a_r11_rx_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> !sclk);

    // R12: disable clears the transmit path on the next cycle.
    a_r12_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy && !sclk && tx_empty);

endmodule

bind spi_dbuf_master spi_dbuf_master_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .wr_stb   (wr_stb),
    .irq_en   (irq_en),
    .tx_empty (tx_empty),
    .irq      (irq),
    .busy     (busy),
    .rx_full  (rx_full),
    .sclk     (sclk),
    .mosi     (mosi)
);

// File: tb/spi_dbuf_master_test.sv
// Scoreboard bench: driver tasks queue expected bytes; a monitor on the
// falling system edge rebuilds MOSI frames, models the slave on MISO and
// compares transmit bytes, receive bytes and SCLK spacing.
module spi_dbuf_master_test;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int DIV_W      = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b1;
    logic [DIV_W-1:0]  clk_half = 8'd1;
    logic              wr_stb = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              irq_en = 1'b0;
    logic              rx_ack = 1'b0;
    logic              miso = 1'b0;
    logic              tx_empty, irq, busy, rx_full, sclk, mosi;
    logic [DATA_W-1:0] rx_data;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;
    bit mon_flush = 1'b0;

    logic [7:0] exp_q[$];
    logic [7:0] rx_q[$];

    spi_dbuf_master #(.DATA_W(DATA_W), .DIV_W(DIV_W)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .clk_half(clk_half),
        .wr_stb(wr_stb), .wr_data(wr_data), .irq_en(irq_en), .rx_ack(rx_ack),
        .miso(miso), .tx_empty(tx_empty), .irq(irq), .busy(busy),
        .rx_data(rx_data), .rx_full(rx_full), .sclk(sclk), .mosi(mosi)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int half_of(logic [DIV_W-1:0] d);
        return (d == 0) ? 1 : int'(d);
    endfunction

    function automatic logic [7:0] slave_pat(int i);
        return 8'(i * 37 + 8'h5A);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: frame rebuild, slave model, receive compare, SCLK spacing.
    initial begin : monitor
        logic       prev_sclk = 1'b0;
        logic [7:0] bits = '0;
        int         nb = 0;
        int         fidx = 0;
        int         since = -1;
        logic [7:0] e;
        forever begin
            @(negedge clk);
            if (mon_flush) begin
                exp_q.delete(); rx_q.delete();
                nb = 0; since = -1; mon_flush = 1'b0;
                prev_sclk = sclk;
                continue;
            end
            if (rx_ack) begin
                rx_ack = 1'b0;
            end else if (rx_full) begin
                if (rx_q.size() == 0) check(0, "R11 rx_unexpected", rx_data, 0);
                else begin
                    e = rx_q.pop_front();
                    check(rx_data == e, "R11 rx_data", rx_data, e);
                end
                rx_ack = 1'b1;
            end
            if (!busy) since = -1;
            if (sclk && !prev_sclk) begin
                if (since >= 0)
                    check(since + 1 == 2 * half_of(clk_half), "R8/R10 sclk_period",
                          since + 1, 2 * half_of(clk_half));
                since = 0;
                bits = {bits[6:0], mosi};
                nb++;
                if (nb == 8) begin
                    if (exp_q.size() == 0) check(0, "R6 tx_unexpected", bits, 0);
                    else begin
                        e = exp_q.pop_front();
                        check(bits == e, "R6 tx_byte_msb_first", bits, e);
                    end
                    rx_q.push_back(slave_pat(fidx));
                    fidx++;
                    nb = 0;
                end
            end else if (since >= 0) begin
                since++;
            end
            miso = slave_pat(fidx)[7 - nb];
            prev_sclk = sclk;
        end
    end

    // Driver: one write strobe; queue the byte if the block is enabled.
    task automatic put(logic [7:0] d);
        @(posedge clk); #1;
        wr_stb = 1'b1; wr_data = d;
        if (en) exp_q.push_back(d);
        @(posedge clk); #1;
        wr_stb = 1'b0;
    endtask

    task automatic put_when_free(logic [7:0] d);
        while (!tx_empty) begin @(posedge clk); #1; end
        put(d);
    endtask

    task automatic wait_idle();
        while (busy || !tx_empty) begin @(posedge clk); #1; end
    endtask

    // Directed single byte from idle: R1, R3, R4 timing.
    task automatic single_byte(logic [7:0] d);
        int cnt = 0;
        @(posedge clk); #1;
        wr_stb = 1'b1; wr_data = d; exp_q.push_back(d);
        @(posedge clk); #1;
        wr_stb = 1'b0;
        check(!tx_empty && !busy, "R1 full_after_write", {tx_empty, busy}, 2'b00);
        @(posedge clk); #1;
        check(tx_empty && busy, "R1/R3 load_frees_buffer", {tx_empty, busy}, 2'b11);
        check(!sclk && mosi == d[7], "R3 first_bit_ready", {sclk, mosi}, {1'b0, d[7]});
        do begin cnt++; @(posedge clk); #1; end while (busy);
        check(cnt == 16 * half_of(clk_half), "R4 busy_length", cnt, 16 * half_of(clk_half));
    endtask

    initial begin : main
        bit low_ok;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        check(tx_empty && !busy && !sclk && !irq && !rx_full, "R1 reset_state",
              {tx_empty, busy, sclk, irq, rx_full}, 5'b10000);

        // R10: zero half-period acts as one, then larger dividers.
        clk_half = 8'd0; single_byte(8'hA5);
        clk_half = 8'd1; single_byte(8'h3C);
        clk_half = 8'd3; single_byte(8'h81);
        wait_idle();

        // R8: back-to-back burst with the buffer refilled each time.
        clk_half = 8'd2;
        put_when_free(8'h11); put_when_free(8'hF0);
        put_when_free(8'h7E); put_when_free(8'hC3);
        wait_idle();
        repeat (2) @(posedge clk); #1;

        // R9: clock idles low across a gap, next byte still correct.
        put(8'h96);
        wait_idle();
        low_ok = 1'b1;
        repeat (20) begin @(posedge clk); #1; if (sclk || busy) low_ok = 1'b0; end
        check(low_ok, "R9 sclk_low_in_gap", low_ok, 1);
        put(8'h69);
        wait_idle();

        // R7: second write to a full holding register replaces the byte.
        clk_half = 8'd4;
        put(8'hAA);
        put(8'h55);
        @(posedge clk); #1;
        wr_stb = 1'b1; wr_data = 8'hE7; exp_q[exp_q.size()-1] = 8'hE7;
        @(posedge clk); #1;
        wr_stb = 1'b0;
        wait_idle();
        repeat (3) @(posedge clk); #1;
        check(exp_q.size() == 0, "R7 replaced_byte_dropped", exp_q.size(), 0);

        // R2: interrupt gating; flag independent of enable.
        irq_en = 1'b0; @(posedge clk); #1;
        check(tx_empty && !irq, "R2 irq_masked", {tx_empty, irq}, 2'b10);
        irq_en = 1'b1; @(posedge clk); #1;
        check(tx_empty && irq, "R2 irq_on", {tx_empty, irq}, 2'b11);
        @(posedge clk); #1;
        wr_stb = 1'b1; wr_data = 8'h0F; exp_q.push_back(8'h0F);
        @(posedge clk); #1;
        wr_stb = 1'b0;
        check(!tx_empty && !irq, "R2 irq_drops_on_write", {tx_empty, irq}, 2'b00);
        wait_idle();
        irq_en = 1'b0;
        repeat (3) @(posedge clk); #1;

        // R12: disable mid-byte, writes ignored, then re-enable.
        clk_half = 8'd3;
        put(8'hDB);
        repeat (10) @(posedge clk); #1;
        put(8'h24);
        en = 1'b0; mon_flush = 1'b1;
        @(posedge clk); #1;
        check(!busy && !sclk && tx_empty, "R12 disable_clears",
              {busy, sclk, tx_empty}, 3'b001);
        put(8'h42);
        check(tx_empty && !busy, "R12 write_ignored", {tx_empty, busy}, 2'b10);
        en = 1'b1;
        repeat (4) @(posedge clk); #1;
        check(!busy && !sclk, "R12 stays_idle_after_enable", {busy, sclk}, 2'b00);

        // R11/R6: a final byte after recovery.
        put(8'hB4);
        wait_idle();
        repeat (4) @(posedge clk); #1;
        check(exp_q.size() == 0 && rx_q.size() == 0 && !rx_full, "R11 all_frames_drained",
              exp_q.size() + rx_q.size(), 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule